// File: doc/BRIEF.md
# Vector Fail-on-First Element Sequencer

This block walks the element positions of one vector operation, from index 0 upward, presenting one index at a time to an element datapath. For each index it holds a request until the datapath returns a status. The status carries an exception flag and a 4-bit condition result. From these the sequencer decides whether to move on, stop normally, raise a trap, or cut the vector length short. When it stops, it reports the effective vector length.

Two early-stop variants exist. The memory variant applies to load/store operations. A fault on the very first element traps as usual. A fault on any later element is swallowed, and the length is cut back to that element's index. The data-driven variant applies to operations that produce a condition result. One selectable, optionally inverted bit of each element's condition result is tested. When the test is true, that element and every later one are cancelled, and the length becomes the element's index. A 5-bit mode word chooses between these variants and the other modes, which leave the element sequence untouched.

Top module: `ffseq_top`

## Requirements
- R1: After an accepted `start` with length N>0, `elem_req` is high and `elem_idx` runs 0,1,...,N-1. The index and request are held until a cycle with `stat_valid`=1. With no early stop, `done` rises in the cycle after the status of index N-1, with `vl_out`=N and `trap_req`=0.
- R2: A `start` with `vl_in`=0 produces no `elem_req`. `done` pulses in the cycle after the start, with `vl_out`=0.
- R3: `start` is ignored while an operation is in progress. The length, index order and result of the running operation are unaffected.
- R4: `mode_in[4:3]` is the mode class: 00 plain, 01 saturating (`mode_in[2]`: 0 unsigned, 1 signed), 10 early-stop/zeroing, 11 treated as plain. Under classes 00, 01 and 11, condition results never shorten the vector.
- R5: Memory early-stop is active when `opclass_in`=01 (load/store) and `mode_in[4:3]`=10, whatever `rc_in` is. An exception on index 0 still raises `trap_req` together with `done`, and `vl_out` keeps the start length.
- R6: With memory early-stop active, an exception on index i≥1 gives no trap. `done` follows the next cycle with `vl_out`=i, and no further index is requested.
- R7: Outside memory early-stop (any class, any index), an exception stops the operation with `trap_req`=1, `done`=1 and `vl_out` equal to the start length.
- R8: Data-driven early-stop is active when `mode_in[4:3]`=10, the class is not load/store, and either `rc_in`=1 or `opclass_in`=10 (compare); `opclass_in`=00 is arithmetic. Its test is `stat_cr[mode_in[1:0]]` XOR `mode_in[2]`. A true test on index i ends the operation with `vl_out`=i and `trap_req`=0; this includes i=0.
- R9: With `mode_in[4:3]`=10, `rc_in`=0 and an arithmetic class, the mode means predicate zeroing, and no truncation takes place.
- R10: When an element reports an exception and a true condition test together, the exception rule wins.
- R11: After reset, `elem_req`, `done`, `trap_req` are 0 and `vl_out` is 0. `done` is a single-cycle pulse, and `trap_req` is high only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| vl_in | input | VLW | Starting vector length |
| mode_in | input | 5 | Mode word, class in [4:3] |
| rc_in | input | 1 | Operation records a condition result |
| opclass_in | input | 2 | 00 arithmetic, 01 load/store, 10 compare |
| elem_idx | output | VLW | Index of the element being requested |
| elem_req | output | 1 | Element request valid |
| stat_valid | input | 1 | Status for the current element is present |
| stat_exc | input | 1 | Current element raised an exception |
| stat_cr | input | 4 | Condition result of the current element |
| trap_req | output | 1 | Normal trap requested (with done) |
| vl_out | output | VLW | Final vector length, valid with done |
| done | output | 1 | Operation finished (one-cycle pulse) |

## Verification
The sequence is run with plain full-length operations, with and without status delays, and with zero length; these separate correct index stepping and holding from a premature or missing finish. Exceptions are placed at index 0 and at a later index, under load/store early-stop and outside it, which tells trap-versus-truncate apart. Condition hits are placed at index 0 and at later indices, with and without inversion and for each activation path (recorded result, compare). The same hit patterns are repeated under the zeroing, saturating, reserved and load/store settings to show that they gate truncation. A stray start during a busy operation, and a coincident exception plus hit, check the ignore and priority rules.

// File: rtl/ffseq_pkg.sv
// Shared types for the fail-on-first element sequencer.
// Assumes a 4-bit condition result per element.
package ffseq_pkg;
    localparam int CR_BITS = 4;
    localparam int CRSEL_W = $clog2(CR_BITS);

    typedef enum logic [1:0] {
        OPC_ARITH = 2'b00,
        OPC_LDST  = 2'b01,
        OPC_CMP   = 2'b10,
        OPC_RSVD  = 2'b11
    } opclass_e;

    typedef enum logic [1:0] {
        MK_PLAIN = 2'b00,
        MK_SAT   = 2'b01,
        MK_STOP  = 2'b10,
        MK_RSVD  = 2'b11
    } modekind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_RUN  = 2'b01,
        S_FIN  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic               mem_stop;
        logic               data_stop;
        logic               inv;
        logic [CRSEL_W-1:0] crsel;
    } seq_cfg_t;
endpackage

// File: rtl/ffseq_mode_dec.sv
// Mode decoder: turns the mode word, record flag and operation class into
// the early-stop controls. Purely combinational; inputs sampled by the caller.
module ffseq_mode_dec
    import ffseq_pkg::*;
(
    input  logic [4:0] mode,
    input  logic       rc,
    input  logic [1:0] opc,
    output seq_cfg_t   cfg
);
    modekind_e kind;
    logic      makes_cr;
    logic      is_mem;

    // Decode the class bits and derive which early-stop variant applies.
    always_comb begin
        kind          = modekind_e'(mode[4:3]);
        is_mem        = (opc == OPC_LDST);
        makes_cr      = rc || (opc == OPC_CMP);
        cfg.mem_stop  = (kind == MK_STOP) && is_mem;
        cfg.data_stop = (kind == MK_STOP) && makes_cr && !is_mem;
        cfg.inv       = mode[2];
        cfg.crsel     = mode[CRSEL_W-1:0];
    end
endmodule

// File: rtl/ffseq_cr_test.sv
// Condition tester: picks one bit of the element's condition result and
// optionally inverts it. Assumes sel is always within range.
module ffseq_cr_test #(
    parameter  int NBITS = 4,
    localparam int SW    = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] cr,
    input  logic [SW-1:0]    sel,
    input  logic             inv,
    output logic             hit
);
    // Select and optionally invert the tested bit.
    always_comb hit = cr[sel] ^ inv;
endmodule

// File: rtl/ffseq_ctrl.sv
// Sequencer control: accepts a start when idle, steps element indices one
// at a time on each status handshake, applies trap / truncation rules and
// emits a one-cycle done with the final length. Synchronous active-low reset.
module ffseq_ctrl
    import ffseq_pkg::*;
#(
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  seq_cfg_t       cfg_in,
    input  logic           stat_valid,
    input  logic           stat_exc,
    input  logic           cr_hit,
    output seq_cfg_t       cfg_q,
    output logic [VLW-1:0] elem_idx,
    output logic           elem_req,
    output logic           trap_req,
    output logic [VLW-1:0] vl_out,
    output logic           done
);
    seq_state_e     state_q;
    logic [VLW-1:0] idx_q;
    logic [VLW-1:0] vl_q;
    logic [VLW-1:0] vlo_q;
    logic           trap_q;
    logic           last_elem;
    logic           trap_now;
    logic           trunc_now;

    // Classify the outcome of the element status presented this cycle.
    always_comb begin
        last_elem = (idx_q == (vl_q - 1'b1));
        trap_now  = stat_exc && !(cfg_q.mem_stop && (idx_q != '0));
        trunc_now = (stat_exc && !trap_now) ||
                    (!stat_exc && cfg_q.data_stop && cr_hit);
    end

    // Main state machine: capture, step, terminate, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            vl_q    <= '0;
            vlo_q   <= '0;
            trap_q  <= 1'b0;
            cfg_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        cfg_q  <= cfg_in;
                        vl_q   <= vl_in;
                        idx_q  <= '0;
                        trap_q <= 1'b0;
                        if (vl_in == '0) begin
                            vlo_q   <= '0;
                            state_q <= S_FIN;
                        end else begin
                            state_q <= S_RUN;
                        end
                    end
                end
                S_RUN: begin
                    if (stat_valid) begin
                        if (trap_now) begin
                            trap_q  <= 1'b1;
                            vlo_q   <= vl_q;
                            state_q <= S_FIN;
                        end else if (trunc_now) begin
                            vlo_q   <= idx_q;
                            state_q <= S_FIN;
                        end else if (last_elem) begin
                            vlo_q   <= vl_q;
                            state_q <= S_FIN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                S_FIN: begin
                    trap_q  <= 1'b0;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the outputs from registered state.
    always_comb begin
        elem_idx = idx_q;
        elem_req = (state_q == S_RUN);
        done     = (state_q == S_FIN);
        trap_req = trap_q;
        vl_out   = vlo_q;
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_req && !stat_valid) |=> (elem_req && $stable(elem_idx)));

    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        elem_req |-> (elem_idx < vl_q));

    p_zero_vl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && vl_in == '0) |=>
            (done && !elem_req && vl_out == '0));

    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start) |=> $stable(vl_q));

    p_mem_trap0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_req && stat_valid && stat_exc && cfg_q.mem_stop && elem_idx == '0) |=>
            (done && trap_req && vl_out == $past(vl_q)));

    p_mem_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_req && stat_valid && stat_exc && cfg_q.mem_stop && elem_idx != '0) |=>
            (done && !trap_req && vl_out == $past(elem_idx)));

    p_data_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_req && stat_valid && !stat_exc && cfg_q.data_stop && cr_hit) |=>
            (done && !trap_req && vl_out == $past(elem_idx)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_trap_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> done);
endmodule

// File: rtl/ffseq_top.sv
// Fail-on-first element sequencer top: decodes the mode from the inputs,
// hands it to the control FSM at start, and tests each element's condition
// result with the captured selection. Synchronous active-low reset.
module ffseq_top
    import ffseq_pkg::*;
#(
    parameter  int MAX_VL = 64,
    localparam int VLW    = $clog2(MAX_VL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VLW-1:0]     vl_in,
    input  logic [4:0]         mode_in,
    input  logic               rc_in,
    input  logic [1:0]         opclass_in,
    output logic [VLW-1:0]     elem_idx,
    output logic               elem_req,
    input  logic               stat_valid,
    input  logic               stat_exc,
    input  logic [CR_BITS-1:0] stat_cr,
    output logic               trap_req,
    output logic [VLW-1:0]     vl_out,
    output logic               done
);
    seq_cfg_t cfg_dec;
    seq_cfg_t cfg_q;
    logic     cr_hit;

    ffseq_mode_dec u_dec (
        .mode (mode_in),
        .rc   (rc_in),
        .opc  (opclass_in),
        .cfg  (cfg_dec)
    );

    ffseq_cr_test #(.NBITS(CR_BITS)) u_crt (
        .cr  (stat_cr),
        .sel (cfg_q.crsel),
        .inv (cfg_q.inv),
        .hit (cr_hit)
    );

    ffseq_ctrl #(.VLW(VLW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vl_in      (vl_in),
        .cfg_in     (cfg_dec),
        .stat_valid (stat_valid),
        .stat_exc   (stat_exc),
        .cr_hit     (cr_hit),
        .cfg_q      (cfg_q),
        .elem_idx   (elem_idx),
        .elem_req   (elem_req),
        .trap_req   (trap_req),
        .vl_out     (vl_out),
        .done       (done)
    );
endmodule

// File: tb/ffseq_top_tb.sv
`timescale 1ns/1ps
module ffseq_top_tb;
    localparam int VLW = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [VLW-1:0] vl_in = '0;
    logic [4:0]     mode_in = '0;
    logic           rc_in = 1'b0;
    logic [1:0]     opclass_in = '0;
    logic [VLW-1:0] elem_idx;
    logic           elem_req;
    logic           stat_valid = 1'b0;
    logic           stat_exc = 1'b0;
    logic [3:0]     stat_cr = '0;
    logic           trap_req;
    logic [VLW-1:0] vl_out;
    logic           done;

    int n_chk = 0;
    int n_fail = 0;
    logic       exc_tab [0:63];
    logic [3:0] cr_tab  [0:63];
    int r_reqs, r_vl, r_trap, r_fin, r_order, r_pulse;

    always #4 clk = ~clk;

    ffseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .mode_in(mode_in), .rc_in(rc_in), .opclass_in(opclass_in),
        .elem_idx(elem_idx), .elem_req(elem_req), .stat_valid(stat_valid),
        .stat_exc(stat_exc), .stat_cr(stat_cr), .trap_req(trap_req),
        .vl_out(vl_out), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_tabs();
        for (int k = 0; k < 64; k++) begin
            exc_tab[k] = 1'b0;
            cr_tab[k]  = 4'h0;
        end
    endtask

    // Runs one operation, answering every request after 'gap' idle cycles.
    task automatic run_op(input int vl, input logic [4:0] md, input logic rc,
                          input logic [1:0] oc, input int gap, input bit poke);
        int seen;
        int fin;
        @(negedge clk);
        start = 1'b1; vl_in = VLW'(vl); mode_in = md; rc_in = rc; opclass_in = oc;
        @(negedge clk);
        start = 1'b0;
        seen = 0; fin = 0; r_order = 1; r_vl = -1; r_trap = -1;
        for (int cyc = 0; cyc < 2000 && fin == 0; cyc++) begin
            if (done) begin
                fin = 1; r_vl = int'(vl_out); r_trap = int'(trap_req);
            end else if (elem_req) begin
                if (int'(elem_idx) != seen) r_order = 0;
                for (int g = 0; g < gap; g++) begin
                    start = poke; vl_in = poke ? VLW'(2) : vl_in;
                    @(negedge clk);
                    start = 1'b0;
                    if (!elem_req || int'(elem_idx) != seen) r_order = 0;
                end
                stat_valid = 1'b1; stat_exc = exc_tab[seen]; stat_cr = cr_tab[seen];
                seen++;
                @(negedge clk);
                stat_valid = 1'b0; stat_exc = 1'b0; stat_cr = 4'h0;
            end else begin
                @(negedge clk);
            end
        end
        r_reqs = seen; r_fin = fin;
        @(negedge clk);
        r_pulse = (done == 1'b0 && trap_req == 1'b0) ? 1 : 0;
    endtask

    task automatic t_reset();
        check("R11 reset elem_req", int'(elem_req), 0);
        check("R11 reset done", int'(done), 0);
        check("R11 reset trap_req", int'(trap_req), 0);
        check("R11 reset vl_out", int'(vl_out), 0);
    endtask

    task automatic t_full_fast();
        clr_tabs();
        run_op(5, 5'b00000, 1'b0, 2'b00, 0, 0);
        check("R1 fast requests", r_reqs, 5);
        check("R1 fast order", r_order, 1);
        check("R1 fast vl", r_vl, 5);
        check("R1 fast trap", r_trap, 0);
        check("R11 done pulse", r_pulse, 1);
    endtask

    task automatic t_full_slow();
        clr_tabs();
        run_op(4, 5'b00000, 1'b1, 2'b00, 3, 0);
        check("R1 held requests", r_reqs, 4);
        check("R1 held order", r_order, 1);
        check("R1 held vl", r_vl, 4);
    endtask

    task automatic t_zero_len();
        clr_tabs();
        run_op(0, 5'b00000, 1'b0, 2'b00, 0, 0);
        check("R2 zero requests", r_reqs, 0);
        check("R2 zero done", r_fin, 1);
        check("R2 zero vl", r_vl, 0);
    endtask

    task automatic t_busy_start();
        clr_tabs();
        run_op(4, 5'b00000, 1'b0, 2'b00, 2, 1);
        check("R3 busy start requests", r_reqs, 4);
        check("R3 busy start order", r_order, 1);
        check("R3 busy start vl", r_vl, 4);
    endtask

    task automatic t_mem_first();
        clr_tabs(); exc_tab[0] = 1'b1;
        run_op(6, 5'b10000, 1'b0, 2'b01, 0, 0);
        check("R5 mem exc0 trap", r_trap, 1);
        check("R5 mem exc0 vl", r_vl, 6);
        check("R5 mem exc0 requests", r_reqs, 1);
    endtask

    task automatic t_mem_later();
        clr_tabs(); exc_tab[3] = 1'b1;
        run_op(7, 5'b10000, 1'b1, 2'b01, 1, 0);
        check("R6 mem exc3 trap", r_trap, 0);
        check("R6 mem exc3 vl", r_vl, 3);
        check("R6 mem exc3 requests", r_reqs, 4);
    endtask

    task automatic t_plain_exc();
        clr_tabs(); exc_tab[2] = 1'b1;
        run_op(8, 5'b00000, 1'b0, 2'b01, 0, 0);
        check("R7 plain exc trap", r_trap, 1);
        check("R7 plain exc vl", r_vl, 8);
        check("R7 plain exc requests", r_reqs, 3);
    endtask

    task automatic t_data_stop();
        clr_tabs(); cr_tab[3] = 4'b0100;
        run_op(9, 5'b10010, 1'b1, 2'b00, 0, 0);
        check("R8 hit3 vl", r_vl, 3);
        check("R8 hit3 trap", r_trap, 0);
        check("R8 hit3 requests", r_reqs, 4);
        clr_tabs();
        for (int k = 0; k < 64; k++) cr_tab[k] = 4'b0100;
        cr_tab[2] = 4'b0000;
        run_op(6, 5'b10110, 1'b1, 2'b00, 0, 0);
        check("R8 inverted vl", r_vl, 2);
        clr_tabs(); cr_tab[1] = 4'b0010;
        run_op(5, 5'b10001, 1'b0, 2'b10, 0, 0);
        check("R8 compare vl", r_vl, 1);
        clr_tabs(); cr_tab[0] = 4'b1000;
        run_op(5, 5'b10011, 1'b1, 2'b00, 0, 0);
        check("R8 hit0 vl", r_vl, 0);
        check("R8 hit0 requests", r_reqs, 1);
        clr_tabs(); cr_tab[1] = 4'b0010;
        run_op(5, 5'b10001, 1'b1, 2'b01, 0, 0);
        check("R8 load/store not data driven", r_vl, 5);
    endtask

    task automatic t_zeroing();
        clr_tabs(); cr_tab[1] = 4'b0010;
        run_op(5, 5'b10001, 1'b0, 2'b00, 0, 0);
        check("R9 zeroing vl", r_vl, 5);
        check("R9 zeroing requests", r_reqs, 5);
    endtask

    task automatic t_other_modes();
        clr_tabs(); cr_tab[1] = 4'b0010;
        run_op(5, 5'b01001, 1'b1, 2'b00, 0, 0);
        check("R4 saturating vl", r_vl, 5);
        run_op(5, 5'b11001, 1'b1, 2'b10, 0, 0);
        check("R4 reserved vl", r_vl, 5);
        run_op(5, 5'b00001, 1'b1, 2'b00, 0, 0);
        check("R4 plain vl", r_vl, 5);
    endtask

    task automatic t_priority();
        clr_tabs(); exc_tab[2] = 1'b1; cr_tab[2] = 4'b0001;
        run_op(6, 5'b10000, 1'b1, 2'b00, 0, 0);
        check("R10 exc over hit trap", r_trap, 1);
        check("R10 exc over hit vl", r_vl, 6);
    endtask

    initial begin
        clr_tabs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_fast();
        t_full_slow();
        t_zero_len();
        t_busy_start();
        t_mem_first();
        t_mem_later();
        t_plain_exc();
        t_data_stop();
        t_zeroing();
        t_other_modes();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule